// File: doc/BRIEF.md
# Dual Instruction Prefetch Buffer

This block sits between an instruction fetch stage and an instruction cache and keeps two fetch-line buffers. Each fetch address is rounded down to the current line size, which is 8 or 16 bytes. If either buffer already holds that line, that buffer becomes the current one. If neither holds it, buffer 0 is used, because that buffer wins when requests compete. When the current buffer does not hold the line, the block issues a demand load into it. When the current buffer does hold the line, the block checks that the other buffer holds the next sequential line, and issues a prefetch if it does not.

Every request carries a fresh tag from a counter that starts at 0x80000000. The cache reports completion by returning that tag. Fetch is held while the current buffer still waits for its data. A branch penalty, loaded beforehand, adds a one-time stall to the first fetch of an instruction packet. When both the cache and cycle accounting are disabled, the block is transparent: it issues nothing and never stalls.

Top module: `ifetch_dual_prefetch`

## Requirements
- R1: Every request address is the fetch address (or the next line) with its low bits cleared, where the line is 16 bytes when `line_wide`=1 and 8 bytes when `line_wide`=0.
- R2: When the aligned address matches the stored line of buffer 0, `cur_buf` is 0. Otherwise, when it matches buffer 1, `cur_buf` is 1.
- R3: A line held by neither buffer causes a demand request (`req_pref`=0) into buffer 0 (`req_buf`=0) for the aligned address.
- R4: Request tags start at 0x80000000 after reset and increase by one with every issued request, whether demand or prefetch.
- R5: When the current buffer holds the line but the other buffer does not hold aligned+line, a prefetch (`req_pref`=1) for aligned+line is issued into the other buffer.
- R6: A demand and a prefetch are never issued together. The demand goes out first, and the prefetch follows on the next fetch cycle.
- R7: `stall` is high during a fetch whose current buffer is missing or still has an outstanding request. A completion whose tag matches that request removes the stall from the following cycle on.
- R8: A completion whose tag matches no outstanding request of either buffer changes nothing.
- R9: After `pen_load` with N, the first N fetch cycles that have `fetch_first`=1 stall. After that, the penalty is zero.
- R10: With `cache_en`=0 and `acct_en`=0, no request is issued, `stall` stays low and the buffers keep their contents.
- R11: After reset, both buffers are empty, no request is issued, `stall` is low and `cur_buf` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_valid | input | 1 | Fetch address presented this cycle |
| fetch_addr | input | AW | Fetch byte address |
| fetch_first | input | 1 | Fetch is the first of its packet |
| line_wide | input | 1 | 1: 16-byte lines, 0: 8-byte lines |
| cache_en | input | 1 | Instruction cache enabled |
| acct_en | input | 1 | Cycle accounting enabled |
| pen_load | input | 1 | Load a branch penalty |
| pen_cycles | input | PW | Penalty length in stall cycles |
| cpl_valid | input | 1 | Cache completion this cycle |
| cpl_tag | input | TW | Tag of the completed request |
| req_valid | output | 1 | Load request issued |
| req_addr | output | AW | Line address of the request |
| req_tag | output | TW | Tag of the request |
| req_buf | output | 1 | Buffer that receives the line |
| req_pref | output | 1 | 1: prefetch, 0: demand |
| stall | output | 1 | Hold the fetch stage |
| cur_buf | output | 1 | Buffer serving the current fetch |

## Verification
Two things can land in the same cycle. The first is a completion for a buffer and a new request that replaces that buffer's line. The second is a penalty countdown and a miss stall. The random phase produces both: completions are often the exact tag a buffer is waiting on, often happen while fetches jump between lines, and penalties are loaded during misses. The bench model treats a completion as landing before the replacement, so the stale completion must leave the new request outstanding. It treats penalty and miss stalls as overlapping, not summed, and compares `stall` and every request field against that model in each cycle.

// File: rtl/ifpb_pkg.sv
package ifpb_pkg;
   // Mask that clears the offset bits of a line of the given size.
   function automatic logic [63:0] line_mask(input logic [63:0] size);
      return ~(size - 64'd1);
   endfunction
endpackage

// File: rtl/ifpb_tag_gen.sv
module ifpb_tag_gen #(
   parameter int TW = 32,
   parameter logic [TW-1:0] TAG_INIT = {1'b1, {(TW-1){1'b0}}}
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          adv,
   output logic [TW-1:0] tag
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   tag <= TAG_INIT;
      else if (adv) tag <= tag + TW'(1);
   end
endmodule

// File: rtl/ifpb_line_buf.sv
module ifpb_line_buf #(
   parameter int AW = 32,
   parameter int TW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [AW-1:0] load_addr,
   input  logic [TW-1:0] load_tag,
   input  logic          cpl_valid,
   input  logic [TW-1:0] cpl_tag,
   output logic          vld,
   output logic [AW-1:0] addr,
   output logic [TW-1:0] tag,
   output logic          pend
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld  <= 1'b0;
         addr <= '0;
         tag  <= '0;
         pend <= 1'b0;
      end else if (load) begin
         vld  <= 1'b1;
         addr <= load_addr;
         tag  <= load_tag;
         pend <= 1'b1;
      end else if (cpl_valid && pend && (cpl_tag == tag)) begin
         pend <= 1'b0;
      end
   end
endmodule

// File: rtl/ifpb_pen_timer.sv
module ifpb_pen_timer #(
   parameter int PW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [PW-1:0] value,
   input  logic          consume,
   output logic          busy
);
   logic [PW-1:0] left;
   assign busy = (left != '0);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                left <= '0;
      else if (load)             left <= value;
      else if (consume && busy)  left <= left - PW'(1);
   end
endmodule

// File: rtl/ifetch_dual_prefetch.sv
module ifetch_dual_prefetch #(
   parameter int AW     = 32,
   parameter int TW     = 32,
   parameter int PW     = 4,
   parameter int LINE_N = 8,
   parameter int LINE_W = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          fetch_valid,
   input  logic [AW-1:0] fetch_addr,
   input  logic          fetch_first,
   input  logic          line_wide,
   input  logic          cache_en,
   input  logic          acct_en,
   input  logic          pen_load,
   input  logic [PW-1:0] pen_cycles,
   input  logic          cpl_valid,
   input  logic [TW-1:0] cpl_tag,
   output logic          req_valid,
   output logic [AW-1:0] req_addr,
   output logic [TW-1:0] req_tag,
   output logic          req_buf,
   output logic          req_pref,
   output logic          stall,
   output logic          cur_buf
);
   import ifpb_pkg::*;

   localparam int NBUF = 2;
   localparam logic [AW-1:0] SZ_N = AW'(LINE_N);
   localparam logic [AW-1:0] SZ_W = AW'(LINE_W);

   if ((LINE_N & (LINE_N - 1)) != 0 || (LINE_W & (LINE_W - 1)) != 0) begin : g_bad_line
      $error("line sizes must be powers of two");
   end
   if (TW < 2 || AW < 4) begin : g_bad_width
      $error("address or tag width too small");
   end

   logic [NBUF-1:0] b_vld, b_pend, b_load;
   logic [AW-1:0]   b_addr [NBUF];
   logic [TW-1:0]   b_tag  [NBUF];
   logic [TW-1:0]   next_tag;

   logic          go, hit0, hit1, cur, oth, cur_hit, pf_hit, dem, pf;
   logic          pen_busy, pen_use;
   logic [AW-1:0] line_sz, aligned, nxt_line, ld_addr;
   logic [63:0]   mask64;

   assign go       = fetch_valid && (cache_en || acct_en);
   assign line_sz  = line_wide ? SZ_W : SZ_N;
   assign mask64   = line_mask(64'(line_sz));
   assign aligned  = fetch_addr & mask64[AW-1:0];
   assign nxt_line = aligned + line_sz;

   assign hit0     = b_vld[0] && (b_addr[0] == aligned);
   assign hit1     = b_vld[1] && (b_addr[1] == aligned);
   assign cur      = !hit0 && hit1;      // buffer 0 preferred, also on a miss
   assign oth      = !cur;
   assign cur_hit  = hit0 || hit1;
   assign pf_hit   = b_vld[oth] && (b_addr[oth] == nxt_line);

   assign dem      = go && !cur_hit;
   assign pf       = go && cur_hit && !pf_hit;
   assign ld_addr  = dem ? aligned : nxt_line;

   for (genvar g = 0; g < NBUF; g++) begin : g_buf
      assign b_load[g] = (dem && (cur == 1'(g))) || (pf && (oth == 1'(g)));
      ifpb_line_buf #(.AW(AW), .TW(TW)) u_buf (
         .clk       (clk),
         .rst_n     (rst_n),
         .load      (b_load[g]),
         .load_addr (ld_addr),
         .load_tag  (next_tag),
         .cpl_valid (cpl_valid),
         .cpl_tag   (cpl_tag),
         .vld       (b_vld[g]),
         .addr      (b_addr[g]),
         .tag       (b_tag[g]),
         .pend      (b_pend[g])
      );
   end

   ifpb_tag_gen #(.TW(TW)) u_tag (
      .clk   (clk),
      .rst_n (rst_n),
      .adv   (dem || pf),
      .tag   (next_tag)
   );

   assign pen_use = go && fetch_first && pen_busy;

   ifpb_pen_timer #(.PW(PW)) u_pen (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (pen_load),
      .value   (pen_cycles),
      .consume (pen_use),
      .busy    (pen_busy)
   );

   assign req_valid = dem || pf;
   assign req_addr  = ld_addr;
   assign req_tag   = next_tag;
   assign req_buf   = dem ? cur : oth;
   assign req_pref  = pf;
   assign stall     = go && (!cur_hit || b_pend[cur] || pen_use);
   assign cur_buf   = go ? cur : 1'b0;
endmodule

// File: rtl/ifpb_checker.sv
module ifpb_checker #(
   parameter int AW = 32,
   parameter int TW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          fetch_valid,
   input logic          line_wide,
   input logic          cache_en,
   input logic          acct_en,
   input logic          req_valid,
   input logic [AW-1:0] req_addr,
   input logic [TW-1:0] req_tag,
   input logic          req_buf,
   input logic          req_pref,
   input logic          stall,
   input logic          cur_buf
);
   logic started;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) started <= 1'b0;
      else        started <= 1'b1;
   end

   assert_aligned_R1: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> (req_addr[2:0] == 3'd0) && (!line_wide || !req_addr[3]));

   assert_demand_to_cur_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_pref) |-> (req_buf == cur_buf) && stall);

   assert_tag_step_R4: assert property (@(posedge clk) disable iff (!rst_n || !started)
      ($past(req_valid) && req_valid) |-> (req_tag == $past(req_tag) + TW'(1)));

   assert_pref_other_R5: assert property (@(posedge clk) disable iff (!rst_n)
      req_pref |-> req_valid && (req_buf != cur_buf));

   assert_stall_needs_fetch_R7: assert property (@(posedge clk) disable iff (!rst_n)
      stall |-> fetch_valid);

   assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(cache_en || acct_en) |-> !req_valid && !stall);
endmodule

bind ifetch_dual_prefetch ifpb_checker #(.AW(AW), .TW(TW)) u_ifpb_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .fetch_valid (fetch_valid),
   .line_wide   (line_wide),
   .cache_en    (cache_en),
   .acct_en     (acct_en),
   .req_valid   (req_valid),
   .req_addr    (req_addr),
   .req_tag     (req_tag),
   .req_buf     (req_buf),
   .req_pref    (req_pref),
   .stall       (stall),
   .cur_buf     (cur_buf)
);

// File: tb/ifetch_dual_prefetch_bench.sv
module ifetch_dual_prefetch_bench;
   localparam int AW = 32, TW = 32, PW = 4;

   logic          clk = 1'b0, rst_n = 1'b0;
   logic          fetch_valid = 0, fetch_first = 0, line_wide = 0;
   logic          cache_en = 1, acct_en = 0, pen_load = 0, cpl_valid = 0;
   logic [AW-1:0] fetch_addr = '0;
   logic [PW-1:0] pen_cycles = '0;
   logic [TW-1:0] cpl_tag = '0;
   logic          req_valid, req_buf, req_pref, stall, cur_buf;
   logic [AW-1:0] req_addr;
   logic [TW-1:0] req_tag;

   always #2.5 clk = ~clk;

   ifetch_dual_prefetch u_ifetch_dual_prefetch (
      .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
      .fetch_first(fetch_first), .line_wide(line_wide), .cache_en(cache_en),
      .acct_en(acct_en), .pen_load(pen_load), .pen_cycles(pen_cycles),
      .cpl_valid(cpl_valid), .cpl_tag(cpl_tag), .req_valid(req_valid),
      .req_addr(req_addr), .req_tag(req_tag), .req_buf(req_buf),
      .req_pref(req_pref), .stall(stall), .cur_buf(cur_buf));

   int n_chk = 0, n_bad = 0;

   // Reference state, built from the requirements.
   logic          m_vld [2];
   logic [AW-1:0] m_adr [2];
   logic [TW-1:0] m_tag [2];
   logic          m_pnd [2];
   logic [TW-1:0] m_ctr;
   int            m_pen;

   task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string what);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
      end
   endtask

   function automatic logic [AW-1:0] align_of(input logic [AW-1:0] a, input logic wide);
      return wide ? (a & ~AW'(15)) : (a & ~AW'(7));
   endfunction

   task automatic model_reset();
      for (int i = 0; i < 2; i++) begin
         m_vld[i] = 0; m_adr[i] = '0; m_tag[i] = '0; m_pnd[i] = 0;
      end
      m_ctr = 32'h8000_0000;
      m_pen = 0;
   endtask

   // Drive one cycle of inputs, compare outputs, advance the model.
   task automatic step(input logic fv, input logic [AW-1:0] a, input logic ff,
                       input logic lw, input logic ce, input logic ae,
                       input logic pl, input int pv, input logic cv,
                       input logic [TW-1:0] ct);
      logic [AW-1:0] al, nx, ln;
      logic h0, h1, c, ch, o, ph, go, dem, pf, pc, e_stall;
      @(posedge clk); #1;
      fetch_valid = fv; fetch_addr = a; fetch_first = ff; line_wide = lw;
      cache_en = ce; acct_en = ae; pen_load = pl; pen_cycles = PW'(pv);
      cpl_valid = cv; cpl_tag = ct;
      #1;
      ln = lw ? AW'(16) : AW'(8);
      al = align_of(a, lw); nx = al + ln;
      h0 = m_vld[0] && m_adr[0] == al;
      h1 = m_vld[1] && m_adr[1] == al;
      c  = !h0 && h1;
      ch = h0 || h1;
      o  = !c;
      ph = m_vld[o] && m_adr[o] == nx;
      go = fv && (ce || ae);
      dem = go && !ch;
      pf  = go && ch && !ph;
      pc  = go && ff && (m_pen != 0);
      e_stall = go && (!ch || m_pnd[c] || pc);
      chk(64'(stall), 64'(e_stall), "R7 stall");
      chk(64'(cur_buf), 64'(go ? c : 1'b0), "R2 cur_buf");
      chk(64'(req_valid), 64'(dem || pf), "R6 req_valid");
      if (dem || pf) begin
         chk(64'(req_addr), 64'(dem ? al : nx), "R1 req_addr");
         chk(64'(req_tag), 64'(m_ctr), "R4 req_tag");
         chk(64'(req_buf), 64'(dem ? c : o), "R3 req_buf");
         chk(64'(req_pref), 64'(pf), "R5 req_pref");
      end
      for (int i = 0; i < 2; i++)
         if (cv && m_pnd[i] && m_tag[i] == ct) m_pnd[i] = 0;
      if (dem || pf) begin
         int b;
         b = dem ? int'(c) : int'(o);
         m_vld[b] = 1; m_adr[b] = dem ? al : nx; m_tag[b] = m_ctr; m_pnd[b] = 1;
         m_ctr = m_ctr + 1;
      end
      if (pl) m_pen = pv;
      else if (pc) m_pen = m_pen - 1;
   endtask

   task automatic idle_step();
      step(0, '0, 0, 0, 1, 0, 0, 0, 0, '0);
   endtask

   initial begin
      #1_000_000;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      model_reset();
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      // R11: reset state
      #1;
      chk(64'(req_valid), 0, "R11 req_valid after reset");
      chk(64'(stall), 0, "R11 stall after reset");
      chk(64'(cur_buf), 0, "R11 cur_buf after reset");

      // R3, R1, R4: miss in both -> demand into buffer 0
      step(1, 32'h1004, 0, 0, 1, 0, 0, 0, 0, '0);
      chk(64'(req_addr), 64'h1000, "R1 demand aligned to 8");
      chk(64'(req_tag), 64'h8000_0000, "R4 first tag");
      chk(64'(req_buf), 0, "R3 miss goes to buffer 0");
      // R6, R5: prefetch follows on the next cycle
      step(1, 32'h1004, 0, 0, 1, 0, 0, 0, 0, '0);
      chk(64'(req_pref), 1, "R6 prefetch after demand");
      chk(64'(req_addr), 64'h1008, "R5 next line");
      // R8: unknown tag ignored, still stalled
      step(1, 32'h1004, 0, 0, 1, 0, 0, 0, 1, 32'h1234);
      step(1, 32'h1004, 0, 0, 1, 0, 0, 0, 1, 32'h8000_0000);
      step(1, 32'h1004, 0, 0, 1, 0, 0, 0, 0, '0);
      chk(64'(stall), 0, "R7 stall released after completion");
      // R2: fetch in buffer 1's line
      step(1, 32'h100c, 0, 0, 1, 0, 0, 0, 1, 32'h8000_0001);
      chk(64'(cur_buf), 1, "R2 hit in buffer 1");
      // R1: 16-byte lines
      step(1, 32'h203c, 0, 1, 1, 0, 0, 0, 0, '0);
      chk(64'(req_addr), 64'h2030, "R1 demand aligned to 16");
      // R10: disabled -> nothing, then same line still missing
      step(1, 32'h5000, 0, 0, 0, 0, 0, 0, 0, '0);
      chk(64'(req_valid), 0, "R10 no request when disabled");
      step(1, 32'h5000, 0, 0, 0, 1, 0, 0, 0, '0);
      chk(64'(req_addr), 64'h5000, "R10 buffers untouched while disabled");
      // R9: penalty of 3 on a resident, completed line
      step(1, 32'h5000, 0, 0, 0, 1, 1, 3, 1, req_tag);
      for (int k = 0; k < 6; k++) step(1, 32'h5000, 1, 0, 0, 1, 0, 0, 1, m_tag[1]);
      chk(64'(stall), 0, "R9 penalty consumed");

      // Constrained random phase
      for (int k = 0; k < 4000; k++) begin
         logic fv, lw, ce, ae, ff, pl, cv;
         logic [AW-1:0] a;
         logic [TW-1:0] ct;
         int r;
         fv = ($urandom % 4) != 0;
         a  = 32'h3000 + ($urandom % 96);
         lw = (k / 300) % 2;
         ce = ($urandom % 10) != 0;
         ae = ($urandom % 2) != 0;
         ff = ($urandom % 5) == 0;
         pl = ($urandom % 30) == 0;
         cv = ($urandom % 5) < 2;
         r  = $urandom % 3;
         ct = (r == 2) ? TW'($urandom) : m_tag[r];
         step(fv, a, ff, lw, ce, ae, pl, $urandom % 6, cv, ct);
      end
      idle_step();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule